// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This engine moves configuration item data between a byte-addressed item store and system memory under the control of a 16-byte descriptor. A host writes the descriptor's memory address into a 64-bit pointer register as two 32-bit halves. The high half sits at offset 0 and the low half at offset 4. The write to the low half starts the operation. The engine then reads the descriptor from memory one byte at a time and decodes its control word. It can optionally select a new item, and then reads item bytes into memory, writes memory bytes into the item, or skips the item offset forward. Last, it stores a result word back over the descriptor's control field.

The selected item key and the running byte offset are a single cursor. The engine and a simple byte-wide host data port both use it. A host selector write or a host data read moves the same cursor that a descriptor moves. Both memory and item store respond combinationally, so each byte moves in one clock cycle. While the engine is idle, a host read of the pointer register returns a fixed identification constant.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset busy_o is low. An idle read of the pointer register returns the identification constant 0x4346_4744_4D41_454E, high word 0x43464744 when reg_lo_i is 0 and low word 0x4D41454E when reg_lo_i is 1.
- R2: A host write with reg_lo_i=0 stores the high 32 bits of the pointer. A write with reg_lo_i=1 stores the low 32 bits and starts an operation. While busy, the pointer register reads back the 64-bit descriptor address that was written.
- R3: The descriptor occupies 16 bytes starting at the pointer. It holds a 32-bit control word, then a 32-bit length, then a 64-bit memory address, each most significant byte first.
- R4: Control bit 3 (select) loads the item key from control bits 31:16 and clears the offset to zero before any transfer of the same descriptor. A descriptor with only select set moves no data.
- R5: Control bit 1 (read) copies length bytes from the item, starting at the current offset, to memory at the descriptor address. Bytes at or past the item length are written as 0x00. The offset advances by length.
- R6: Control bit 4 (write) with bit 1 clear copies length bytes from memory into the item at the current offset, and the offset advances by length. When bits 1 and 4 are both set, the descriptor performs a read.
- R7: A write is rejected if the item is read-only or if offset plus length exceeds the item length. A rejected write sets the error result, changes no item byte and leaves the offset unchanged.
- R8: Control bit 2 (skip), with bits 1 and 4 clear, advances the offset by length and moves no data.
- R9: On completion the engine writes the four control bytes at the descriptor address as 00 00 00 00 on success or 00 00 00 01 on error. It then clears the pointer register and drops busy_o.
- R10: Host pointer writes made while busy_o is high are ignored and start no second operation.
- R11: While idle, data_o shows the item byte at the cursor, or 0x00 at or past the item length. A data_rd_i pulse advances the offset by one. A sel_we_i pulse loads sel_key_i and clears the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Pointer register write strobe |
| reg_lo_i | input | 1 | Half select for register access: 0 high word, 1 low word |
| reg_wdata_i | input | 32 | Pointer register write data |
| reg_rdata_o | output | 32 | Pointer register read data for the half chosen by reg_lo_i |
| sel_we_i | input | 1 | Host selector write strobe |
| sel_key_i | input | 16 | Host selector key |
| data_rd_i | input | 1 | Host data read strobe, consumes one byte |
| data_o | output | 8 | Host data byte at the cursor |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 64 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, combinational from mem_addr_o |
| item_key_o | output | 16 | Selected item key |
| item_off_o | output | 32 | Item byte address being accessed |
| item_len_i | input | 32 | Length of the selected item |
| item_ro_i | input | 1 | Selected item is read-only |
| item_rdata_i | input | 8 | Item byte at item_off_o, combinational |
| item_we_o | output | 1 | Item byte write strobe |
| item_wdata_o | output | 8 | Item write byte |

## Verification
The hardest cases are a rejected write and a trigger that arrives while an operation is running. Neither one leaves a direct trace at the ports. The stimulus chains descriptors so that the cursor carries over between them. A skip leaves the offset mid-item, and an oversized write without select is then issued from that offset. Reading the host data port afterwards shows that neither the item bytes nor the offset moved. The stray trigger is sent during a read that is still in progress, and its target descriptor is left in memory. Any write-back to that descriptor would show up at the memory-write monitor as an extra write that was never expected.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int CTRL_RD   = 1;
  localparam int CTRL_SKIP = 2;
  localparam int CTRL_SEL  = 3;
  localparam int CTRL_WR   = 4;
  localparam logic [63:0] DMA_MAGIC = 64'h4346_4744_4D41_454E;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEL, ST_CHECK, ST_RD, ST_WR, ST_WB
  } seq_state_e;
endpackage

// File: rtl/cfg_dma_hostreg.sv
module cfg_dma_hostreg #(
  parameter int AW = 64,
  parameter logic [AW-1:0] MAGIC = cfg_dma_pkg::DMA_MAGIC[AW-1:0]
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_lo_i,
  input  logic [AW/2-1:0] reg_wdata_i,
  output logic [AW/2-1:0] reg_rdata_o,
  input  logic            busy_i,
  input  logic            done_i,
  output logic            trig_o,
  output logic [AW-1:0]   ptr_o
);
  localparam int HW = AW / 2;

  logic [HW-1:0] hi_q, lo_q;
  logic          trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (done_i) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (reg_we_i && !busy_i) begin
        if (reg_lo_i) begin
          lo_q   <= reg_wdata_i;
          trig_q <= 1'b1;
        end else begin
          hi_q <= reg_wdata_i;
        end
      end
    end
  end

  assign trig_o = trig_q;
  assign ptr_o  = {hi_q, lo_q};

  always_comb begin
    if (busy_i) reg_rdata_o = reg_lo_i ? lo_q : hi_q;
    else        reg_rdata_o = reg_lo_i ? MAGIC[HW-1:0] : MAGIC[AW-1:HW];
  end

  a_r2_low_half_triggers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_lo_i && !busy_i && !done_i) |=> trig_o);
  a_r9_ptr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ptr_o == '0));
  a_r10_busy_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && busy_i && !done_i) |=> ($stable(ptr_o) && !trig_o));
endmodule

// File: rtl/cfg_dma_cursor.sv
module cfg_dma_cursor #(
  parameter int KW = 16,
  parameter int OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_sel_i,
  input  logic [KW-1:0] host_key_i,
  input  logic          host_step_i,
  input  logic          dma_sel_i,
  input  logic [KW-1:0] dma_key_i,
  input  logic          dma_adv_i,
  input  logic [OW-1:0] dma_len_i,
  output logic [KW-1:0] key_o,
  output logic [OW-1:0] off_o
);
  logic [KW-1:0] key_q;
  logic [OW-1:0] off_q;

  // engine requests take priority; host strobes are gated by the top while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      off_q <= '0;
    end else if (dma_sel_i) begin
      key_q <= dma_key_i;
      off_q <= '0;
    end else if (dma_adv_i) begin
      off_q <= off_q + dma_len_i;
    end else if (host_sel_i) begin
      key_q <= host_key_i;
      off_q <= '0;
    end else if (host_step_i) begin
      off_q <= off_q + OW'(1);
    end
  end

  assign key_o = key_q;
  assign off_o = off_q;

  a_r4_select_zeroes_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_sel_i || host_sel_i) |=> (off_o == '0));
  a_r8_advance_by_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_adv_i && !dma_sel_i) |=> (off_o == $past(off_o) + $past(dma_len_i)));
endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
  import cfg_dma_pkg::*;
#(
  parameter int AW = 64,
  parameter int KW = 16,
  parameter int OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [AW-1:0] ptr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic [OW-1:0] cur_off_i,
  input  logic [OW-1:0] item_len_i,
  input  logic          item_ro_i,
  input  logic [7:0]    item_rdata_i,
  output logic          item_we_o,
  output logic [7:0]    item_wdata_o,
  output logic [OW-1:0] xfer_idx_o,
  output logic          dma_sel_o,
  output logic [KW-1:0] dma_key_o,
  output logic          dma_adv_o,
  output logic [OW-1:0] dma_len_o
);
  localparam int DESC_B = 16;
  localparam int DESC_W = DESC_B * 8;
  localparam int IW     = $clog2(DESC_B);
  localparam int WB_B   = 4;

  seq_state_e    st_q;
  logic [AW-1:0] ptr_q;
  logic [DESC_W-1:0] desc_q;
  logic [IW-1:0] idx_q;
  logic [OW-1:0] cnt_q;
  logic          err_q;

  logic [31:0]   ctrl_w, len_w;
  logic [AW-1:0] maddr_w;
  logic [OW-1:0] len_o;
  logic [OW:0]   wr_end, cur_pos;
  logic          wr_reject, in_range, last_byte;

  assign ctrl_w  = desc_q[DESC_W-1 -: 32];
  assign len_w   = desc_q[DESC_W-33 -: 32];
  assign maddr_w = AW'(desc_q[63:0]);
  assign len_o   = OW'(len_w);

  assign wr_end    = {1'b0, cur_off_i} + {1'b0, len_o};
  assign wr_reject = item_ro_i || (wr_end > {1'b0, item_len_i});
  assign cur_pos   = {1'b0, cur_off_i} + {1'b0, cnt_q};
  assign in_range  = cur_pos < {1'b0, item_len_i};
  assign last_byte = (cnt_q == len_o - OW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      desc_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (trig_i) begin
          ptr_q <= ptr_i;
          idx_q <= '0;
          err_q <= 1'b0;
          st_q  <= ST_FETCH;
        end
        ST_FETCH: begin
          desc_q <= {desc_q[DESC_W-9:0], mem_rdata_i};
          idx_q  <= idx_q + IW'(1);
          if (idx_q == IW'(DESC_B - 1)) st_q <= ST_SEL;
        end
        ST_SEL: st_q <= ST_CHECK;
        ST_CHECK: begin
          cnt_q <= '0;
          idx_q <= '0;
          if (ctrl_w[CTRL_RD]) begin
            st_q <= (len_o == '0) ? ST_WB : ST_RD;
          end else if (ctrl_w[CTRL_WR]) begin
            if (wr_reject) begin
              err_q <= 1'b1;
              st_q  <= ST_WB;
            end else begin
              st_q <= (len_o == '0) ? ST_WB : ST_WR;
            end
          end else begin
            st_q <= ST_WB;
          end
        end
        ST_RD, ST_WR: begin
          cnt_q <= cnt_q + OW'(1);
          if (last_byte) st_q <= ST_WB;
        end
        ST_WB: begin
          idx_q <= idx_q + IW'(1);
          if (idx_q == IW'(WB_B - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = '0;
    mem_wdata_o  = '0;
    item_we_o    = 1'b0;
    item_wdata_o = '0;
    xfer_idx_o   = '0;
    dma_sel_o    = 1'b0;
    dma_adv_o    = 1'b0;
    done_o       = 1'b0;
    case (st_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + AW'(idx_q);
      end
      ST_SEL: dma_sel_o = ctrl_w[CTRL_SEL];
      ST_CHECK: dma_adv_o = !ctrl_w[CTRL_RD] && !ctrl_w[CTRL_WR] && ctrl_w[CTRL_SKIP];
      ST_RD: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = maddr_w + AW'(cnt_q);
        mem_wdata_o = in_range ? item_rdata_i : 8'h00;
        xfer_idx_o  = cnt_q;
        dma_adv_o   = last_byte;
      end
      ST_WR: begin
        mem_req_o    = 1'b1;
        mem_addr_o   = maddr_w + AW'(cnt_q);
        item_we_o    = 1'b1;
        item_wdata_o = mem_rdata_i;
        xfer_idx_o   = cnt_q;
        dma_adv_o    = last_byte;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q + AW'(idx_q);
        mem_wdata_o = (idx_q == IW'(WB_B - 1)) ? {7'd0, err_q} : 8'h00;
        done_o      = (idx_q == IW'(WB_B - 1));
      end
      default: ;
    endcase
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign dma_key_o = ctrl_w[31:32-KW];
  assign dma_len_o = len_o;

  a_r7_no_item_write_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !item_we_o);
  a_r7_item_write_in_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_we_o |-> (in_range && !item_ro_i));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
  parameter int AW = 64,
  parameter int KW = 16,
  parameter int OW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_lo_i,
  input  logic [AW/2-1:0] reg_wdata_i,
  output logic [AW/2-1:0] reg_rdata_o,
  input  logic            sel_we_i,
  input  logic [KW-1:0]   sel_key_i,
  input  logic            data_rd_i,
  output logic [7:0]      data_o,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  input  logic [7:0]      mem_rdata_i,
  output logic [KW-1:0]   item_key_o,
  output logic [OW-1:0]   item_off_o,
  input  logic [OW-1:0]   item_len_i,
  input  logic            item_ro_i,
  input  logic [7:0]      item_rdata_i,
  output logic            item_we_o,
  output logic [7:0]      item_wdata_o
);
  logic          trig, seq_busy, done, busy;
  logic [AW-1:0] ptr;
  logic [OW-1:0] cur_off, xfer_idx, dma_len;
  logic [KW-1:0] dma_key;
  logic          dma_sel, dma_adv;

  assign busy   = trig | seq_busy;
  assign busy_o = busy;

  cfg_dma_hostreg #(.AW(AW)) i_hostreg (
    .clk_i, .rst_ni, .reg_we_i, .reg_lo_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_i(done), .trig_o(trig), .ptr_o(ptr)
  );

  cfg_dma_cursor #(.KW(KW), .OW(OW)) i_cursor (
    .clk_i, .rst_ni,
    .host_sel_i(sel_we_i & ~busy), .host_key_i(sel_key_i),
    .host_step_i(data_rd_i & ~busy),
    .dma_sel_i(dma_sel), .dma_key_i(dma_key),
    .dma_adv_i(dma_adv), .dma_len_i(dma_len),
    .key_o(item_key_o), .off_o(cur_off)
  );

  cfg_dma_seq #(.AW(AW), .KW(KW), .OW(OW)) i_seq (
    .clk_i, .rst_ni, .trig_i(trig), .ptr_i(ptr),
    .busy_o(seq_busy), .done_o(done),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .cur_off_i(cur_off), .item_len_i, .item_ro_i, .item_rdata_i,
    .item_we_o, .item_wdata_o, .xfer_idx_o(xfer_idx),
    .dma_sel_o(dma_sel), .dma_key_o(dma_key),
    .dma_adv_o(dma_adv), .dma_len_o(dma_len)
  );

  assign item_off_o = cur_off + xfer_idx;
  assign data_o     = ({1'b0, cur_off} < {1'b0, item_len_i}) ? item_rdata_i : 8'h00;

  a_r11_past_end_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && ({1'b0, item_off_o} >= {1'b0, item_len_i})) |-> (data_o == 8'h00));
endmodule

// File: tb/test_cfg_dma_engine.sv
`timescale 1ns/100ps
module test_cfg_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_we = 0, reg_lo = 0, sel_we = 0, data_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] sel_key = 0, item_key;
  logic [7:0]  data_o, mem_wdata, mem_rdata, item_rdata, item_wdata;
  logic        busy, mem_req, mem_we, item_ro, item_we;
  logic [63:0] mem_addr;
  logic [31:0] item_off, item_len;

  logic [7:0] mem [256];
  logic [7:0] itm [4][16];

  typedef struct { logic [7:0] a; logic [7:0] d; string tag; } exp_t;
  exp_t exp_q [$];
  int tests = 0, fails = 0;

  cfg_dma_engine i_cfg_dma_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_lo_i(reg_lo),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .sel_we_i(sel_we),
    .sel_key_i(sel_key), .data_rd_i(data_rd), .data_o(data_o), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .item_key_o(item_key),
    .item_off_o(item_off), .item_len_i(item_len), .item_ro_i(item_ro),
    .item_rdata_i(item_rdata), .item_we_o(item_we), .item_wdata_o(item_wdata)
  );

  // item store model: key0 8 bytes read-only, key1 16 bytes, key2 4 bytes
  assign item_len   = (item_key == 16'd0) ? 32'd8 : (item_key == 16'd1) ? 32'd16 :
                      (item_key == 16'd2) ? 32'd4 : 32'd0;
  assign item_ro    = (item_key == 16'd0);
  assign item_rdata = (item_key < 16'd4 && item_off < 32'd16) ? itm[item_key[1:0]][item_off[3:0]] : 8'h00;
  assign mem_rdata  = mem[mem_addr[7:0]];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: every memory write is compared with the next expected one
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected write: actual %h@%h expected none", mem_wdata, mem_addr[7:0]);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (mem_addr[7:0] !== e.a || mem_wdata !== e.d) begin
          fails++;
          $display("FAIL %s: actual %h@%h expected %h@%h", e.tag, mem_wdata, mem_addr[7:0], e.d, e.a);
        end
      end
      mem[mem_addr[7:0]] = mem_wdata;
    end
    if (rst_n && item_we && item_key < 16'd4 && item_off < 32'd16)
      itm[item_key[1:0]][item_off[3:0]] = item_wdata;
  end

  task automatic push(input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_wb(input logic [7:0] at, input logic err);
    for (int i = 0; i < 3; i++) push(at + 8'(i), 8'h00, "R9 result word");
    push(at + 8'd3, {7'd0, err}, err ? "R7 error result" : "R9 success result");
  endtask

  task automatic put_desc(input logic [7:0] at, input logic [31:0] ctrl,
                          input logic [31:0] len, input logic [7:0] buf_a);
    logic [127:0] d;
    d = {ctrl, len, 56'd0, buf_a};
    for (int i = 0; i < 16; i++) mem[at + 8'(i)] = d[127 - 8*i -: 8];
  endtask

  task automatic trigger(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk); reg_we = 1; reg_lo = 0; reg_wdata = hi;
    @(negedge clk); reg_lo = 1; reg_wdata = lo;
    @(negedge clk); reg_we = 0; reg_lo = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk("R9 busy drops", busy, 0);
    chk("R9 no pending expected writes", exp_q.size(), 0);
  endtask

  task automatic host_sel(input logic [15:0] k);
    @(negedge clk); sel_we = 1; sel_key = k;
    @(negedge clk); sel_we = 0;
  endtask

  task automatic host_rd();
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 16; i++) begin
      mem[8'h80 + i] = 8'hC0 + 8'(i);
      itm[0][i] = 8'hA0 + 8'(i);
      itm[1][i] = 8'h10 + 8'(i);
      itm[2][i] = 8'h20 + 8'(i);
      itm[3][i] = 8'h30 + 8'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", busy, 0);
    reg_lo = 0; #1 chk("R1 magic high", reg_rdata, 32'h43464744);
    reg_lo = 1; #1 chk("R1 magic low", reg_rdata, 32'h4D41454E);
    reg_lo = 0;
    chk("R11 data port at reset", data_o, 8'hA0);

    // R3 R4 R5 select key0 and read 4 bytes
    put_desc(8'h00, 32'h0000_000A, 32'd4, 8'h40);
    for (int i = 0; i < 4; i++) push(8'h40 + 8'(i), 8'hA0 + 8'(i), "R5 read data");
    push_wb(8'h00, 0);
    trigger(32'h0, 32'h0);
    wait_idle();
    chk("R5 offset advanced", data_o, 8'hA4);

    // R5 read past end, R2 pointer readback, R10 trigger while busy
    put_desc(8'h10, 32'h0000_0002, 32'd6, 8'h48);
    put_desc(8'h20, 32'h0001_0008, 32'd0, 8'h00);
    for (int i = 0; i < 4; i++) push(8'h48 + 8'(i), 8'hA4 + 8'(i), "R5 read tail");
    push(8'h4C, 8'h00, "R5 zero fill");
    push(8'h4D, 8'h00, "R5 zero fill");
    push_wb(8'h10, 0);
    trigger(32'h1234_5678, 32'h10);
    reg_lo = 0; #1 chk("R2 busy high word", reg_rdata, 32'h1234_5678);
    @(negedge clk); reg_we = 1; reg_lo = 1; reg_wdata = 32'h20;
    @(negedge clk); reg_we = 0;
    #1 chk("R10 low word kept", reg_rdata, 32'h10);
    reg_lo = 0;
    wait_idle();
    chk("R11 past end reads zero", data_o, 8'h00);
    reg_lo = 1; #1 chk("R9 idle reads magic", reg_rdata, 32'h4D41454E);
    reg_lo = 0;
    chk("R10 stray descriptor untouched", mem[8'h23], 8'h08);

    // R7 write to read-only item
    put_desc(8'h30, 32'h0000_0018, 32'd2, 8'h80);
    push_wb(8'h30, 1);
    trigger(32'h0, 32'h30);
    wait_idle();
    host_sel(16'd0);
    chk("R7 read-only item unchanged", data_o, 8'hA0);

    // R6 write into key1
    put_desc(8'h50, 32'h0001_0018, 32'd4, 8'h80);
    push_wb(8'h50, 0);
    trigger(32'h0, 32'h50);
    wait_idle();
    chk("R6 offset advanced", data_o, 8'h14);
    host_sel(16'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 written byte via R11 step", data_o, 8'hC0 + 8'(i));
      host_rd();
    end

    // R7 write past end of key2
    put_desc(8'h60, 32'h0002_0018, 32'd5, 8'h80);
    push_wb(8'h60, 1);
    trigger(32'h0, 32'h60);
    wait_idle();
    host_sel(16'd2);
    for (int i = 0; i < 4; i++) begin
      chk("R7 oversize write left item", data_o, 8'h20 + 8'(i));
      host_rd();
    end

    // R8 skip
    put_desc(8'h70, 32'h0001_000C, 32'd3, 8'h00);
    push_wb(8'h70, 0);
    trigger(32'h0, 32'h70);
    wait_idle();
    chk("R8 skip offset", data_o, 8'hC3);

    // R7 write without select ending past end keeps offset
    put_desc(8'h90, 32'h0000_0010, 32'd14, 8'h80);
    push_wb(8'h90, 1);
    trigger(32'h0, 32'h90);
    wait_idle();
    chk("R7 offset unchanged", data_o, 8'hC3);

    // R6 read takes precedence when read and write both set
    put_desc(8'hA0, 32'h0000_0012, 32'd1, 8'h4F);
    push(8'h4F, 8'hC3, "R6 read precedence");
    push_wb(8'hA0, 0);
    trigger(32'h0, 32'hA0);
    wait_idle();

    // R4 select only
    put_desc(8'hB0, 32'h0002_0008, 32'd7, 8'h40);
    push_wb(8'hB0, 0);
    trigger(32'h0, 32'hB0);
    wait_idle();
    chk("R4 select only offset zero", data_o, 8'h20);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule